// File: doc/BRIEF.md
# Queue Interrupt Source Controller

This block turns the status flags of a 64-queue FIFO manager into two interrupt lines. The queues are split into a lower half and an upper half, and each half has its own line. Every lower-half queue has a 3-bit source setting. Two of its bits pick one of the queue's four status flags, and the third bit inverts the chosen flag. The upper-half queues have no setting: each one triggers when it stops being nearly empty.

A rising edge of a queue's trigger condition latches a pending bit. This happens whether or not the queue is enabled. Each half has an enable register, and a half's line is high while any of its pending bits is also enabled. Software writes ones to clear pending bits. When it disables a queue, it is expected to clear that queue's pending bit straight after. Registers are reached through a single-cycle write strobe and a combinational read mux. Queue storage and the computation of the status flags belong to the surrounding manager.

Top module: `qirq_ctrl`

## Requirements
- R1: After reset, all source, enable and pending registers read zero, and both interrupt lines are low.
- R2: Lower queue q takes its status as the nibble `low_status[4q+3:4q]`. Source bits [1:0] pick the bit of that nibble that acts as the trigger condition.
- R3: Source bit 2 set means the trigger condition is the inverse of the selected status bit.
- R4: Upper queue q has the trigger condition NOT `hi_near_empty[q]`, and its pending bit is bit q of the upper pending register.
- R5: A pending bit is set one clock after the edge where its trigger condition goes from 0 to 1, whether or not the queue is enabled. A condition that stays high does not set the bit again.
- R6: Writing the lower pending register (select 6) or the upper pending register (select 7) clears exactly the bits written as 1. Bits written as 0 keep their value.
- R7: When a set and a write-one-to-clear hit the same pending bit in the same cycle, the bit ends up set.
- R8: `irq_lo` is high exactly when (lower pending AND lower enable) is nonzero, and `irq_hi` is the same for the upper half. Enables are at select 4 (lower) and select 5 (upper), bit q for queue q.
- R9: A source write changes the trigger from the next cycle on. The written queues take the new condition's present value as their edge history, so a condition that is already true does not set pending.
- R10: Source word k (select k, 0 to 3) holds queues 8k to 8k+7. Queue 8k+j sits in bits [4j+2:4j], and bit 4j+3 is reserved and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| low_status | input | 128 | Four status flags per lower queue, one nibble each |
| hi_near_empty | input | 32 | Nearly-empty flag per upper queue |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Register select for the read |
| rd_data | output | 32 | Read data for rd_sel |
| irq_lo | output | 1 | Interrupt line for the lower half |
| irq_hi | output | 1 | Interrupt line for the upper half |

## Verification
The bench builds the block with its default of 32 queues per half. This gives four full source words and 32-bit enable and pending registers, so every slot position is exercised, including the reserved bit in each slot. Directed phases target each source code, edge suppression after a source write, and the set-versus-clear collision. A long random phase then mixes status changes, writes to every select and reads of every select. A behavioural model checks both lines and the read data on every cycle.

// File: rtl/qirq_pkg.sv
package qirq_pkg;
    localparam int SLOT_W   = 4;   // bits per queue slot in a source word
    localparam int SRC_W    = 3;   // used bits per slot
    localparam int Q_PER_W  = 8;   // queues per source word
    localparam int REG_W    = 32;  // register width
    localparam int SEL_W    = 3;   // register select width

    // trigger condition from a status nibble and a source code
    function automatic logic pick_trig(input logic [SLOT_W-1:0] nib,
                                       input logic [SRC_W-1:0]  src);
        return nib[src[1:0]] ^ src[2];
    endfunction
endpackage

// File: rtl/qirq_trigger.sv
module qirq_trigger
    import qirq_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [N*SLOT_W-1:0] status,
    input  logic [N*SRC_W-1:0]  src,
    output logic [N-1:0]        trig
);
    for (genvar q = 0; q < N; q++) begin : g_q
        assign trig[q] = pick_trig(status[q*SLOT_W +: SLOT_W], src[q*SRC_W +: SRC_W]);
    end
endmodule

// File: rtl/qirq_pending.sv
module qirq_pending #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] trig,
    input  logic [N-1:0] hist_load,
    input  logic [N-1:0] hist_val,
    input  logic [N-1:0] w1c,
    output logic [N-1:0] pend
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] pend;
    } st_t;

    st_t          s_d, s_q;
    logic [N-1:0] set_vec;

    always_comb begin
        s_d      = s_q;
        set_vec  = trig & ~s_q.prev;
        s_d.pend = (s_q.pend & ~w1c) | set_vec;
        s_d.prev = (trig & ~hist_load) | (hist_val & hist_load);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend = s_q.pend;

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((pend & $past(set_vec)) == $past(set_vec))); // R5
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_vec & w1c) != '0) |=> ((pend & $past(set_vec & w1c)) == $past(set_vec & w1c))); // R7
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c != '0) |=> ((pend & $past(w1c & ~set_vec)) == '0)); // R6
    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & $past(s_q.pend & ~w1c)) == $past(s_q.pend & ~w1c))); // R6
endmodule

// File: rtl/qirq_ctrl.sv
module qirq_ctrl
    import qirq_pkg::*;
#(
    parameter int NQ_HALF = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NQ_HALF*SLOT_W-1:0] low_status,
    input  logic [NQ_HALF-1:0]        hi_near_empty,
    input  logic                      wr_en,
    input  logic [SEL_W-1:0]          wr_sel,
    input  logic [REG_W-1:0]          wr_data,
    input  logic [SEL_W-1:0]          rd_sel,
    output logic [REG_W-1:0]          rd_data,
    output logic                      irq_lo,
    output logic                      irq_hi
);
    localparam int NSRCW     = NQ_HALF / Q_PER_W;
    localparam int SEL_EN_LO = NSRCW;
    localparam int SEL_EN_HI = NSRCW + 1;
    localparam int SEL_PD_LO = NSRCW + 2;
    localparam int SEL_PD_HI = NSRCW + 3;

    typedef struct packed {
        logic [NQ_HALF*SRC_W-1:0] src;
        logic [NQ_HALF-1:0]       en_lo;
        logic [NQ_HALF-1:0]       en_hi;
    } regs_t;

    regs_t                r_d, r_q;
    logic [NQ_HALF-1:0]   trig_lo, trig_hi;
    logic [NQ_HALF-1:0]   hist_load, hist_val;
    logic [NQ_HALF-1:0]   w1c_lo, w1c_hi;
    logic [NQ_HALF-1:0]   pend_lo, pend_hi;
    logic [NQ_HALF-1:0]   zero_vec;

    assign zero_vec = '0;
    assign trig_hi  = ~hi_near_empty;

    qirq_trigger #(.N(NQ_HALF)) u_trig (
        .status (low_status),
        .src    (r_q.src),
        .trig   (trig_lo)
    );

    qirq_pending #(.N(NQ_HALF)) u_pend_lo (
        .clk, .rst_n,
        .trig      (trig_lo),
        .hist_load (hist_load),
        .hist_val  (hist_val),
        .w1c       (w1c_lo),
        .pend      (pend_lo)
    );

    qirq_pending #(.N(NQ_HALF)) u_pend_hi (
        .clk, .rst_n,
        .trig      (trig_hi),
        .hist_load (zero_vec),
        .hist_val  (zero_vec),
        .w1c       (w1c_hi),
        .pend      (pend_hi)
    );

    // write decode and next register values
    always_comb begin
        r_d       = r_q;
        hist_load = '0;
        hist_val  = '0;
        w1c_lo    = '0;
        w1c_hi    = '0;
        if (wr_en) begin
            for (int q = 0; q < NQ_HALF; q++) begin
                if (int'(wr_sel) == q / Q_PER_W) begin
                    r_d.src[q*SRC_W +: SRC_W] = wr_data[(q % Q_PER_W)*SLOT_W +: SRC_W];
                    hist_load[q] = 1'b1;
                    hist_val[q]  = pick_trig(low_status[q*SLOT_W +: SLOT_W],
                                             wr_data[(q % Q_PER_W)*SLOT_W +: SRC_W]);
                end
            end
            if (int'(wr_sel) == SEL_EN_LO) r_d.en_lo = wr_data[NQ_HALF-1:0];
            if (int'(wr_sel) == SEL_EN_HI) r_d.en_hi = wr_data[NQ_HALF-1:0];
            if (int'(wr_sel) == SEL_PD_LO) w1c_lo    = wr_data[NQ_HALF-1:0];
            if (int'(wr_sel) == SEL_PD_HI) w1c_hi    = wr_data[NQ_HALF-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // read mux
    always_comb begin
        rd_data = '0;
        for (int q = 0; q < NQ_HALF; q++) begin
            if (int'(rd_sel) == q / Q_PER_W)
                rd_data[(q % Q_PER_W)*SLOT_W +: SRC_W] = r_q.src[q*SRC_W +: SRC_W];
        end
        if (int'(rd_sel) == SEL_EN_LO) rd_data[NQ_HALF-1:0] = r_q.en_lo;
        if (int'(rd_sel) == SEL_EN_HI) rd_data[NQ_HALF-1:0] = r_q.en_hi;
        if (int'(rd_sel) == SEL_PD_LO) rd_data[NQ_HALF-1:0] = pend_lo;
        if (int'(rd_sel) == SEL_PD_HI) rd_data[NQ_HALF-1:0] = pend_hi;
    end

    assign irq_lo = |(pend_lo & r_q.en_lo);
    assign irq_hi = |(pend_hi & r_q.en_hi);

    AST_LO_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.en_lo == '0) |-> !irq_lo); // R8
    AST_HI_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.en_hi == '0) |-> !irq_hi); // R8
    AST_SRC_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == '0) |=> (r_q.src[SRC_W-1:0] == $past(wr_data[SRC_W-1:0]))); // R9
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_sel) < NSRCW) |-> (rd_data[SLOT_W-1] == 1'b0)); // R10
endmodule

// File: tb/qirq_ctrl_tb.sv
module qirq_ctrl_tb;
    localparam int NQ = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NQ*4-1:0] low_status = '0;
    logic [NQ-1:0] hi_near_empty = '1;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_sel = '0;
    logic [31:0]   wr_data = '0;
    logic [2:0]    rd_sel = '0;
    logic [31:0]   rd_data;
    logic          irq_lo, irq_hi;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    qirq_ctrl #(.NQ_HALF(NQ)) u_dut (
        .clk, .rst_n, .low_status, .hi_near_empty,
        .wr_en, .wr_sel, .wr_data, .rd_sel, .rd_data, .irq_lo, .irq_hi
    );

    // behavioural reference model
    logic [2:0]  m_src [NQ];
    logic [31:0] m_en_lo, m_en_hi, m_pd_lo, m_pd_hi;
    logic [31:0] m_prev_lo, m_prev_hi;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int q = 0; q < NQ; q++) m_src[q] = 3'd0;
            m_en_lo = 0; m_en_hi = 0; m_pd_lo = 0; m_pd_hi = 0;
            m_prev_lo = 0; m_prev_hi = 0;
        end else begin
            logic [31:0] tl, th;
            for (int q = 0; q < NQ; q++) begin
                tl[q] = low_status[q*4 + int'(m_src[q][1:0])] ^ m_src[q][2];
                th[q] = !hi_near_empty[q];
            end
            if (wr_en && wr_sel == 3'd6) m_pd_lo = m_pd_lo & ~wr_data;
            if (wr_en && wr_sel == 3'd7) m_pd_hi = m_pd_hi & ~wr_data;
            m_pd_lo = m_pd_lo | (tl & ~m_prev_lo);
            m_pd_hi = m_pd_hi | (th & ~m_prev_hi);
            m_prev_lo = tl;
            m_prev_hi = th;
            if (wr_en && wr_sel < 3'd4) begin
                for (int j = 0; j < 8; j++) begin
                    int q;
                    q = int'(wr_sel) * 8 + j;
                    m_src[q] = wr_data[j*4 +: 3];
                    m_prev_lo[q] = low_status[q*4 + int'(m_src[q][1:0])] ^ m_src[q][2];
                end
            end
            if (wr_en && wr_sel == 3'd4) m_en_lo = wr_data;
            if (wr_en && wr_sel == 3'd5) m_en_hi = wr_data;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [2:0] s);
        logic [31:0] v;
        v = 0;
        if (s < 3'd4) begin
            for (int j = 0; j < 8; j++) v[j*4 +: 3] = m_src[int'(s)*8 + j];
        end
        else if (s == 3'd4) v = m_en_lo;
        else if (s == 3'd5) v = m_en_hi;
        else if (s == 3'd6) v = m_pd_lo;
        else v = m_pd_hi;
        return v;
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    // compare every cycle, away from the edge
    always @(posedge clk) begin
        #2;
        chk("irq_lo", {31'd0, irq_lo}, {31'd0, |(m_pd_lo & m_en_lo)});
        chk("irq_hi", {31'd0, irq_hi}, {31'd0, |(m_pd_hi & m_en_hi)});
        chk("rd_data", rd_data, exp_rd(rd_sel));
    end

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset values on every select
        for (int s = 0; s < 8; s++) begin
            @(negedge clk); rd_sel = 3'(s);
        end
        @(negedge clk); rst_n = 1'b1;
        for (int s = 0; s < 8; s++) begin
            @(negedge clk); rd_sel = 3'(s);
        end

        // R2: queue 3 selects status bit 1
        cur_req = "R2";
        rd_sel = 3'd6;
        wr(3'd0, 32'h0000_1000);
        wr(3'd4, 32'h0000_0008);
        @(negedge clk); low_status[13] = 1'b1;
        idle(3);
        @(negedge clk); low_status[12] = 1'b1; // unselected bit, no effect
        idle(2);

        // R9: queue 9 inverted bit 0, condition already true -> no set
        cur_req = "R9";
        wr(3'd1, 32'h0000_0040);
        idle(3);
        // R3: inverted edge
        cur_req = "R3";
        @(negedge clk); low_status[36] = 1'b1;
        @(negedge clk); low_status[36] = 1'b0;
        idle(3);

        // R6: clear with ones, zeros keep
        cur_req = "R6";
        wr(3'd6, 32'h0000_0008);
        idle(2);
        wr(3'd6, 32'h0000_0000);
        idle(2);

        // R4/R8 upper half
        cur_req = "R4";
        rd_sel = 3'd7;
        @(negedge clk); hi_near_empty[5] = 1'b0;
        idle(3);
        cur_req = "R8";
        wr(3'd5, 32'h0000_0020);
        idle(2);
        wr(3'd5, 32'h0000_0000);
        wr(3'd7, 32'hFFFF_FFFF);
        idle(2);

        // R7: set and clear in the same cycle
        cur_req = "R7";
        @(negedge clk); hi_near_empty[5] = 1'b1;
        @(negedge clk);
        hi_near_empty[5] = 1'b0;
        wr_en = 1'b1; wr_sel = 3'd7; wr_data = 32'h0000_0020;
        @(negedge clk); wr_en = 1'b0;
        idle(2);

        // R5: level held does not re-set after clear
        cur_req = "R5";
        wr(3'd7, 32'h0000_0020);
        idle(4);

        // R10: reserved bits read zero
        cur_req = "R10";
        rd_sel = 3'd2;
        wr(3'd2, 32'hFFFF_FFFF);
        idle(2);
        wr(3'd2, 32'h0000_0000);

        // random mix
        cur_req = "R5/R8";
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            rd_sel = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 3) == 0) low_status[$urandom_range(0, NQ*4-1)] ^= 1'b1;
            if ($urandom_range(0, 3) == 0) hi_near_empty[$urandom_range(0, NQ-1)] ^= 1'b1;
            wr_en = ($urandom_range(0, 4) == 0);
            wr_sel = 3'($urandom_range(0, 7));
            wr_data = $urandom();
        end
        @(negedge clk); wr_en = 1'b0;
        idle(3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule